// File: doc/BRIEF.md
# Color-Keyed Sprite Blitter

This block stamps a rectangular sprite of 8-bit palette pixels into the off-screen half of a double-buffered frame memory. A single start pulse hands over the sprite's screen origin (signed, so a sprite may hang off any edge), its width and height, a transparent key value, and the current displayed bank. The block then fetches the sprite one pixel per cycle from sprite storage in row-major order and writes each pixel into the frame buffer at its screen location. Pixels that carry the key value, and pixels that land outside the visible area, produce no write, so whatever background was drawn earlier shows through.

The frame is addressed linearly, one byte per pixel, row after row. The throughput is one sprite pixel per cycle with a fixed three-cycle pipeline fill. At the default sizes, a full 80 x 80 sprite takes 6403 cycles, which is a small fraction of a 60 Hz frame at any usual fabric clock.

Top module: `sprite_blit`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `fb_we` and `src_rd` are all low.
- R2: A `start` seen while idle captures origin, size, key and bank; for a non-empty sprite `busy` is high in the following cycle.
- R3: Sprite storage is read exactly width x height times, one read per cycle, at addresses 0, 1, 2, ... in row-major order (address = row x width + column). Read data is expected one cycle after the `src_rd` cycle.
- R4: A visible, non-key pixel at sprite row r, column c is written with its own value at frame address (org_y + r) x SCR_W + (org_x + c). Pixels are written in read order.
- R5: A sprite pixel whose value equals the key color is never written.
- R6: `org_x` and `org_y` are two's complement. A pixel whose screen column lies outside 0..SCR_W-1, or whose screen row lies outside 0..SCR_H-1, is dropped without any write. No write address is ever SCR_W x SCR_H or above.
- R7: For a sprite of N = width x height > 0 pixels, `done` is high for exactly one cycle, N+3 cycles after the edge that accepted `start`. `busy` falls at that same edge.
- R8: A start with width 0 or height 0 performs no read and no write, and raises `done` for one cycle right after the accepting edge.
- R9: `start` is ignored while `busy` or `done` is high. Captured parameters stay unchanged, and no extra read, write or `done` occurs.
- R10: A width or height above MAX_SPR is treated as MAX_SPR.
- R11: Every write carries `fb_bank` equal to the inverse of `disp_bank` as sampled at the accepting edge. `fb_bank` holds steady for the whole copy even if `disp_bank` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (taken only when idle) |
| org_x | input | POS_W | Signed screen column of sprite pixel (0,0) |
| org_y | input | POS_W | Signed screen row of sprite pixel (0,0) |
| spr_w | input | SZ_W | Sprite width in pixels |
| spr_h | input | SZ_W | Sprite height in pixels |
| key_color | input | 8 | Transparent palette value |
| disp_bank | input | 1 | Bank currently being displayed |
| src_rd | output | 1 | Sprite storage read enable |
| src_addr | output | SRC_AW | Sprite storage read address |
| src_data | input | 8 | Sprite pixel, one cycle after the read |
| fb_we | output | 1 | Frame-buffer write strobe |
| fb_addr | output | FB_AW | Linear frame-buffer address |
| fb_data | output | 8 | Pixel value to write |
| fb_bank | output | 1 | Bank targeted by the writes (off-screen bank) |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |

## Verification
The bench builds the block with a 12 x 10 screen and a maximum sprite side of 6. Every width and height from 0 to 7 can then be combined with origins that push the sprite past the left, right, top and bottom edges, fully off screen, or fully inside. Size 7 reaches the clamp to the maximum, and size 0 reaches the empty-copy path. The whole frame is small enough to compare in full after every copy, against a model computed arithmetically in the bench. Some copies also drive `start` during the busy and done cycles, and `disp_bank` toggles throughout, to show that neither has any effect.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int PIX_W       = 8;
  localparam int DEF_SCR_W   = 224;
  localparam int DEF_SCR_H   = 200;
  localparam int DEF_MAX_SPR = 80;

  typedef logic [PIX_W-1:0] pix_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int POS_W   = 10,
  parameter int SZ_W    = 7,
  parameter int MAX_SPR = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [POS_W-1:0] org_x,
  input  logic [POS_W-1:0] org_y,
  input  logic [SZ_W-1:0]  spr_w,
  input  logic [SZ_W-1:0]  spr_h,
  input  pix_t             key_in,
  input  logic             disp_bank,
  input  logic             retire,
  output logic             launch,
  output logic [POS_W-1:0] x_q,
  output logic [POS_W-1:0] y_q,
  output logic [SZ_W-1:0]  w_q,
  output logic [SZ_W-1:0]  h_q,
  output pix_t             key_q,
  output logic             bank_q,
  output logic             busy,
  output logic             done
);

  localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(MAX_SPR);

  logic            accept, empty;
  logic [SZ_W-1:0] w_clamp, h_clamp;

  assign accept  = start && !busy && !done;
  assign empty   = (spr_w == '0) || (spr_h == '0);
  assign launch  = accept && !empty;
  assign w_clamp = (spr_w > SZ_MAX) ? SZ_MAX : spr_w;
  assign h_clamp = (spr_h > SZ_MAX) ? SZ_MAX : spr_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
      w_q    <= '0;
      h_q    <= '0;
      key_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      done <= (accept && empty) || retire;
      if (accept) begin
        x_q    <= org_x;
        y_q    <= org_y;
        w_q    <= w_clamp;
        h_q    <= h_clamp;
        key_q  <= key_in;
        bank_q <= !disp_bank;
      end
      if (launch)      busy <= 1'b1;
      else if (retire) busy <= 1'b0;
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_clears_r7: assert property (@(posedge clk) disable iff (rst)
    retire |=> !busy && done);

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(x_q) && $stable(y_q) && $stable(w_q) && $stable(h_q) && $stable(key_q));

  p_bank_hold_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(bank_q));

endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int SCR_W  = 224,
  parameter int SCR_H  = 200,
  parameter int POS_W  = 10,
  parameter int SZ_W   = 7,
  parameter int SRC_AW = 13,
  parameter int FB_AW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [POS_W-1:0]  x_q,
  input  logic [POS_W-1:0]  y_q,
  input  logic [SZ_W-1:0]   w_q,
  input  logic [SZ_W-1:0]   h_q,
  output logic              src_rd,
  output logic [SRC_AW-1:0] src_addr,
  output logic              inb1,
  output logic [FB_AW-1:0]  fba1,
  output logic              last1
);

  localparam int XW = $clog2(SCR_W);
  localparam int YW = $clog2(SCR_H);
  localparam int PAD = POS_W + 1 - SZ_W;
  localparam logic signed [POS_W:0] LIM_X = (POS_W+1)'(SCR_W);
  localparam logic signed [POS_W:0] LIM_Y = (POS_W+1)'(SCR_H);

  logic              active;
  logic [SZ_W-1:0]   row, col;
  logic [SRC_AW-1:0] idx;
  logic signed [POS_W:0] sx, sy;
  logic              inb, row_end, is_last;
  logic [FB_AW-1:0]  fba;

  assign sx = $signed({x_q[POS_W-1], x_q}) + $signed({{PAD{1'b0}}, col});
  assign sy = $signed({y_q[POS_W-1], y_q}) + $signed({{PAD{1'b0}}, row});
  assign inb = !sx[POS_W] && !sy[POS_W] && (sx < LIM_X) && (sy < LIM_Y);
  assign fba = FB_AW'(sy[YW-1:0]) * FB_AW'(SCR_W) + FB_AW'(sx[XW-1:0]);
  assign row_end = (col + SZ_W'(1)) == w_q;
  assign is_last = row_end && ((row + SZ_W'(1)) == h_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      row      <= '0;
      col      <= '0;
      idx      <= '0;
      src_rd   <= 1'b0;
      src_addr <= '0;
      inb1     <= 1'b0;
      fba1     <= '0;
      last1    <= 1'b0;
    end else if (launch) begin
      active <= 1'b1;
      row    <= '0;
      col    <= '0;
      idx    <= '0;
      src_rd <= 1'b0;
    end else if (active) begin
      src_rd   <= 1'b1;
      src_addr <= idx;
      inb1     <= inb;
      fba1     <= fba;
      last1    <= is_last;
      idx      <= idx + SRC_AW'(1);
      if (row_end) begin
        col <= '0;
        row <= row + SZ_W'(1);
      end else begin
        col <= col + SZ_W'(1);
      end
      if (is_last) active <= 1'b0;
    end else begin
      src_rd <= 1'b0;
    end
  end

  p_src_bound_r3: assert property (@(posedge clk) disable iff (rst)
    src_rd |-> int'(src_addr) < int'(w_q) * int'(h_q));

  p_src_step_r3: assert property (@(posedge clk) disable iff (rst)
    src_rd && $past(src_rd) && !$past(last1) |-> src_addr == $past(src_addr) + SRC_AW'(1));

endmodule

// File: rtl/blit_writer.sv
module blit_writer
  import blit_pkg::*;
#(
  parameter int FB_AW    = 16,
  parameter int FB_CELLS = 44800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v1,
  input  logic             inb1,
  input  logic [FB_AW-1:0] fba1,
  input  logic             last1,
  input  pix_t             src_data,
  input  pix_t             key_q,
  output logic             fb_we,
  output logic [FB_AW-1:0] fb_addr,
  output pix_t             fb_data,
  output logic             retire
);

  logic             v2, inb2, last2;
  logic [FB_AW-1:0] fba2;

  assign retire = v2 && last2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2      <= 1'b0;
      inb2    <= 1'b0;
      last2   <= 1'b0;
      fba2    <= '0;
      fb_we   <= 1'b0;
      fb_addr <= '0;
      fb_data <= '0;
    end else begin
      v2      <= v1;
      inb2    <= inb1;
      last2   <= last1;
      fba2    <= fba1;
      fb_we   <= v2 && inb2 && (src_data != key_q);
      fb_addr <= fba2;
      fb_data <= src_data;
    end
  end

  p_key_drop_r5: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> fb_data != key_q);

  p_fb_bound_r6: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> int'(fb_addr) < FB_CELLS);

endmodule

// File: rtl/sprite_blit.sv
module sprite_blit
  import blit_pkg::*;
#(
  parameter int SCR_W   = DEF_SCR_W,
  parameter int SCR_H   = DEF_SCR_H,
  parameter int MAX_SPR = DEF_MAX_SPR,
  localparam int POS_W  = $clog2(max2(SCR_W, SCR_H) + MAX_SPR) + 1,
  localparam int SZ_W   = $clog2(MAX_SPR + 1),
  localparam int SRC_AW = $clog2(MAX_SPR * MAX_SPR),
  localparam int FB_AW  = $clog2(SCR_W * SCR_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [POS_W-1:0]  org_x,
  input  logic [POS_W-1:0]  org_y,
  input  logic [SZ_W-1:0]   spr_w,
  input  logic [SZ_W-1:0]   spr_h,
  input  logic [7:0]        key_color,
  input  logic              disp_bank,
  output logic              src_rd,
  output logic [SRC_AW-1:0] src_addr,
  input  logic [7:0]        src_data,
  output logic              fb_we,
  output logic [FB_AW-1:0]  fb_addr,
  output logic [7:0]        fb_data,
  output logic              fb_bank,
  output logic              busy,
  output logic              done
);

  logic             launch, retire;
  logic [POS_W-1:0] x_q, y_q;
  logic [SZ_W-1:0]  w_q, h_q;
  pix_t             key_q;
  logic             inb1, last1;
  logic [FB_AW-1:0] fba1;

  blit_ctrl #(.POS_W(POS_W), .SZ_W(SZ_W), .MAX_SPR(MAX_SPR)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .org_x(org_x), .org_y(org_y), .spr_w(spr_w), .spr_h(spr_h),
    .key_in(key_color), .disp_bank(disp_bank), .retire(retire),
    .launch(launch), .x_q(x_q), .y_q(y_q), .w_q(w_q), .h_q(h_q),
    .key_q(key_q), .bank_q(fb_bank), .busy(busy), .done(done)
  );

  blit_walker #(
    .SCR_W(SCR_W), .SCR_H(SCR_H), .POS_W(POS_W), .SZ_W(SZ_W),
    .SRC_AW(SRC_AW), .FB_AW(FB_AW)
  ) u_walker (
    .clk(clk), .rst(rst), .launch(launch),
    .x_q(x_q), .y_q(y_q), .w_q(w_q), .h_q(h_q),
    .src_rd(src_rd), .src_addr(src_addr),
    .inb1(inb1), .fba1(fba1), .last1(last1)
  );

  blit_writer #(.FB_AW(FB_AW), .FB_CELLS(SCR_W * SCR_H)) u_writer (
    .clk(clk), .rst(rst), .v1(src_rd), .inb1(inb1), .fba1(fba1),
    .last1(last1), .src_data(src_data), .key_q(key_q),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data), .retire(retire)
  );

endmodule

// File: tb/test_sprite_blit.sv
`timescale 1ns/1ps
module test_sprite_blit;

  localparam int W = 12, H = 10, M = 6;
  localparam int POS_W = 6, SZ_W = 3, SRC_AW = 6, FB_AW = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start, disp_bank;
  logic [POS_W-1:0] org_x, org_y;
  logic [SZ_W-1:0]  spr_w, spr_h;
  logic [7:0]       key_color, src_data, fb_data;
  logic             src_rd, fb_we, fb_bank, busy, done;
  logic [SRC_AW-1:0] src_addr;
  logic [FB_AW-1:0]  fb_addr;

  sprite_blit #(.SCR_W(W), .SCR_H(H), .MAX_SPR(M)) i_sprite_blit (
    .clk(clk), .rst(rst), .start(start), .org_x(org_x), .org_y(org_y),
    .spr_w(spr_w), .spr_h(spr_h), .key_color(key_color), .disp_bank(disp_bank),
    .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data), .fb_bank(fb_bank),
    .busy(busy), .done(done)
  );

  logic [7:0] spr_mem [M*M];
  logic [7:0] frame   [W*H];
  logic [7:0] expf    [W*H];

  int n_tests = 0, n_fail = 0;
  int rd_cnt, wr_cnt, bad_bank, bad_addr, bad_order;
  logic exp_bank;

  always @(posedge clk) begin
    if (src_rd) src_data <= (int'(src_addr) < M*M) ? spr_mem[src_addr] : 8'hxx;
  end

  always @(negedge clk) begin
    if (src_rd) begin
      if (int'(src_addr) != rd_cnt) bad_order++;
      rd_cnt++;
    end
    if (fb_we) begin
      wr_cnt++;
      if (fb_bank !== exp_bank) bad_bank++;
      if (int'(fb_addr) >= W*H) bad_addr++;
      else frame[fb_addr] = fb_data;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic run(int x, int y, int w, int h, int key, bit bank, bit poke, int seed);
    int we_, he_, n, first, dn, mm, limit;
    we_ = (w > M) ? M : w;
    he_ = (h > M) ? M : h;
    n = we_ * he_;
    for (int i = 0; i < M*M; i++)
      spr_mem[i] = (i % 4 == 1) ? 8'(key) : 8'(i*29 + seed*7 + 1);
    for (int a = 0; a < W*H; a++) begin
      frame[a] = 8'(a*3 + seed);
      expf[a]  = frame[a];
    end
    for (int r = 0; r < he_; r++)
      for (int c = 0; c < we_; c++) begin
        int sx, sy;
        sx = x + c;
        sy = y + r;
        if (sx >= 0 && sx < W && sy >= 0 && sy < H && spr_mem[r*we_+c] != 8'(key))
          expf[sy*W+sx] = spr_mem[r*we_+c];
      end
    rd_cnt = 0; wr_cnt = 0; bad_bank = 0; bad_addr = 0; bad_order = 0;
    exp_bank = !bank;
    @(negedge clk);
    org_x = POS_W'(x); org_y = POS_W'(y);
    spr_w = SZ_W'(w);  spr_h = SZ_W'(h);
    key_color = 8'(key); disp_bank = bank; start = 1'b1;
    first = -1; dn = 0; limit = n + 10;
    for (int cyc = 1; cyc <= limit; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      disp_bank = bank ^ cyc[0];
      if (cyc == 1) chk(busy == (n > 0), "R2", "busy after start", int'(busy), int'(n > 0));
      if (done) begin
        dn++;
        if (first < 0) first = cyc;
      end
      if (poke && n > 0 && cyc == 2) begin
        start = 1'b1; org_x = POS_W'(x + 1); spr_w = 3'd1; spr_h = 3'd1;
      end
      if (poke && done) begin
        start = 1'b1; spr_w = 3'd0;
      end
    end
    start = 1'b0;
    mm = 0;
    for (int a = 0; a < W*H; a++) if (frame[a] !== expf[a]) mm++;
    if (n == 0) chk(first == 1, "R8", "empty done cycle", first, 1);
    else        chk(first == n + 3, "R7", "done cycle", first, n + 3);
    chk(dn == 1, "R9", "done pulses", dn, 1);
    chk(rd_cnt == n && bad_order == 0, "R3", "read count/order", rd_cnt, n);
    chk(mm == 0, (w > M || h > M) ? "R10 R4 R5 R6" : "R4 R5 R6", "frame mismatches", mm, 0);
    chk(bad_bank == 0 && bad_addr == 0, "R11", "bank/addr errors", bad_bank + bad_addr, 0);
  endtask

  initial begin
    automatic int xs[5] = '{-6, -2, 0, 7, 11};
    automatic int ys[5] = '{-6, 0, 5, 9, 10};
    automatic int seed = 0;
    rst = 1'b1; start = 1'b0; disp_bank = 1'b0;
    org_x = '0; org_y = '0; spr_w = '0; spr_h = '0; key_color = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !fb_we && !src_rd, "R1", "outputs in reset",
        int'({busy, done, fb_we, src_rd}), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !fb_we && !src_rd, "R1", "outputs after reset",
        int'({busy, done, fb_we, src_rd}), 0);
    for (int w = 0; w <= 7; w++)
      for (int h = 0; h <= 7; h++)
        for (int xi = 0; xi < 5; xi++)
          for (int yi = 0; yi < 5; yi++) begin
            run(xs[xi], ys[yi], w, h, (seed*37) & 255, seed[0], (seed % 7) == 3, seed);
            seed++;
          end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule